// File: doc/BRIEF.md
# Two-Stage Layer Compositor

The block combines up to four rectangular layers into a single output pixel stream. Every layer carries an enable, an origin and an extent on the output raster, a pipe select, a priority, an 8-bit global alpha and an alpha enable. The caller presents a raster position each cycle, together with the pixel that each layer would contribute at that position. The block returns the composited pixel a fixed number of cycles later.

Composition happens in two stages. The first stage handles each of the two pipes separately. Among the enabled layers that cover the position and belong to that pipe, it selects one winner by priority, and it does no mixing inside a pipe. The second stage lays the pipe 0 winner over the background colour, then lays the pipe 1 winner over that result, each step using the winning layer's alpha. A compatibility switch reproduces a known defect: the lowest-priority pipe 0 layer is dropped to background whenever it is translucent.

Fetching pixels from memory and decoding pixel formats are handled outside this block.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, out_valid is 0.
- R2: A position presented with pix_valid=1 inside the frame produces out_valid=1 with its out_pix on the second rising clock edge after it is sampled. In every other case out_valid is 0.
- R3: A position with pix_x >= frame_w or pix_y >= frame_h never produces a valid output.
- R4: Layer i occupies bits [i*W +: W] of each per-layer port. It covers positions with org_x <= x < org_x+ext_w and org_y <= y < org_y+ext_h, and only while its lay_en bit is 1. A disabled layer has no effect on the output.
- R5: Inside each pipe, the covering layer with the numerically highest lay_prio supplies that pipe's pixel. Lower-priority layers in the same pipe are not mixed in.
- R6: When two covering layers in the same pipe have equal lay_prio, the layer with the lower index wins.
- R7: A position covered by no layer in either pipe outputs bg_color.
- R8: A layer's effective alpha is lay_alpha when its lay_alpha_en bit is 1, and 255 otherwise. Mixing a top over a bottom gives (a*top + (255-a)*bottom + 127)/255 in integer arithmetic, per 8-bit channel. The channels sit at bits 23:16, 15:8 and 7:0.
- R9: lay_pipe bit 0 selects pipe 0 and bit 1 selects pipe 1. The pipe 0 winner is mixed over bg_color, and the pipe 1 winner is then mixed over that result. A pipe with no winner passes its bottom through unchanged.
- R10: With flaw_mode=1, a pipe 0 winner whose lay_prio is 0 and whose effective alpha is below 255 is replaced by bg_color. The pipe 1 winner is still mixed over it. An opaque priority-0 layer is unaffected.
- R11: A layer with ext_w=0 or ext_h=0 covers no position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_w | input | COORD_W | Output frame width in pixels |
| frame_h | input | COORD_W | Output frame height in lines |
| bg_color | input | 24 | Background RGB colour |
| flaw_mode | input | 1 | Enables the blanking of a translucent priority-0 pipe 0 layer |
| lay_en | input | NUM_LAYERS | Per-layer enable |
| lay_org_x | input | NUM_LAYERS*COORD_W | Per-layer left edge |
| lay_org_y | input | NUM_LAYERS*COORD_W | Per-layer top edge |
| lay_ext_w | input | NUM_LAYERS*COORD_W | Per-layer width |
| lay_ext_h | input | NUM_LAYERS*COORD_W | Per-layer height |
| lay_pipe | input | NUM_LAYERS | Per-layer pipe select |
| lay_prio | input | NUM_LAYERS*PRIO_W | Per-layer priority, higher wins |
| lay_alpha | input | NUM_LAYERS*8 | Per-layer global alpha |
| lay_alpha_en | input | NUM_LAYERS | Per-layer alpha enable |
| pix_valid | input | 1 | The raster position is valid |
| pix_x | input | COORD_W | Raster column |
| pix_y | input | COORD_W | Raster line |
| lay_pix | input | NUM_LAYERS*24 | Each layer's RGB pixel at this position |
| out_valid | output | 1 | out_pix holds a composited pixel |
| out_pix | output | 24 | Composited RGB pixel |

## Verification
Each position, together with the layer pixels and configuration sampled alongside it, yields its result on the second rising edge after it is sampled. The block has no other delay and no stall. The bench drives one position per falling edge. It pushes the value it computes for that position into a two-entry queue, and it compares the outputs two falling edges later, which falls between the second and third rising edges. Every sweep ends with two idle positions, so that a configuration change never overlaps a result still in flight.

// File: rtl/comp_pkg.sv
package comp_pkg;
    localparam int CH_W   = 8;
    localparam int NUM_CH = 3;
    localparam int PIX_W  = CH_W * NUM_CH;
    localparam int ACC_W  = 2 * CH_W + 1;

    localparam logic [CH_W-1:0] ALPHA_OPAQUE = '1;

    typedef logic [CH_W-1:0]  alpha_t;
    typedef logic [PIX_W-1:0] rgb_t;

    // Winner of one pipe: found, forced to background, its alpha and pixel.
    typedef struct packed {
        logic   found;
        logic   blank;
        alpha_t alpha;
        rgb_t   pix;
    } pick_t;

    // Registered state of both pipeline stages.
    typedef struct packed {
        logic   s1_v;
        logic   s1_top_hit;
        alpha_t s1_top_a;
        rgb_t   s1_top_pix;
        rgb_t   s1_bot;
        logic   out_v;
        rgb_t   out_pix;
    } pipe_state_t;

    // Rounded a*top + (max-a)*bottom over max, for one channel.
    function automatic logic [CH_W-1:0] mix_chan(input alpha_t a,
                                                 input logic [CH_W-1:0] top,
                                                 input logic [CH_W-1:0] bot);
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(a) * ACC_W'(top)
            + ACC_W'(ALPHA_OPAQUE - a) * ACC_W'(bot)
            + ACC_W'(ALPHA_OPAQUE >> 1);
        return CH_W'(acc / ACC_W'(ALPHA_OPAQUE));
    endfunction
endpackage

// File: rtl/comp_layer_hit.sv
module comp_layer_hit #(
    parameter int COORD_W = 12
) (
    input  logic               en,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] ext_w,
    input  logic [COORD_W-1:0] ext_h,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    output logic               hit
);
    localparam int SUM_W = COORD_W + 1;

    logic [SUM_W-1:0] lim_x;
    logic [SUM_W-1:0] lim_y;
    logic             in_x;
    logic             in_y;

    // One extra bit so that a rectangle touching the coordinate limit does not wrap.
    assign lim_x = SUM_W'(org_x) + SUM_W'(ext_w);
    assign lim_y = SUM_W'(org_y) + SUM_W'(ext_h);
    assign in_x  = (pos_x >= org_x) && (SUM_W'(pos_x) < lim_x);
    assign in_y  = (pos_y >= org_y) && (SUM_W'(pos_y) < lim_y);
    assign hit   = en && in_x && in_y;
endmodule

// File: rtl/comp_pipe_pick.sv
module comp_pipe_pick
    import comp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int PRIO_W     = 2,
    parameter bit PIPE_ID    = 1'b0,
    parameter bit FLAW_ABLE  = 1'b0
) (
    input  logic [NUM_LAYERS-1:0]        hits,
    input  logic [NUM_LAYERS-1:0]        pipe_of,
    input  logic [NUM_LAYERS*PRIO_W-1:0] prio_flat,
    input  logic [NUM_LAYERS*CH_W-1:0]   alpha_flat,
    input  logic [NUM_LAYERS*PIX_W-1:0]  pix_flat,
    input  logic                         flaw_mode,
    output pick_t                        pick
);
    logic              found;
    logic [PRIO_W-1:0] best_prio;
    alpha_t            best_alpha;
    rgb_t              best_pix;

    // Ascending scan with a strict compare: on equal priority the lower index stays.
    always_comb begin
        found      = 1'b0;
        best_prio  = '0;
        best_alpha = '0;
        best_pix   = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (hits[i] && (pipe_of[i] == PIPE_ID) &&
                (!found || (prio_flat[i*PRIO_W +: PRIO_W] > best_prio))) begin
                found      = 1'b1;
                best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
                best_alpha = alpha_flat[i*CH_W +: CH_W];
                best_pix   = pix_flat[i*PIX_W +: PIX_W];
            end
        end
    end

    always_comb begin
        pick.found = found;
        pick.alpha = best_alpha;
        pick.pix   = best_pix;
        pick.blank = FLAW_ABLE && flaw_mode && found &&
                     (best_prio == '0) && (best_alpha != ALPHA_OPAQUE);
    end
endmodule

// File: rtl/comp_blend.sv
module comp_blend
    import comp_pkg::*;
(
    input  alpha_t alpha,
    input  rgb_t   top,
    input  rgb_t   bot,
    output rgb_t   mix
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign mix[ch*CH_W +: CH_W] = mix_chan(alpha, top[ch*CH_W +: CH_W],
                                               bot[ch*CH_W +: CH_W]);
    end
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
    import comp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int COORD_W    = 12,
    parameter int PRIO_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [COORD_W-1:0]            frame_w,
    input  logic [COORD_W-1:0]            frame_h,
    input  logic [PIX_W-1:0]              bg_color,
    input  logic                          flaw_mode,
    input  logic [NUM_LAYERS-1:0]         lay_en,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_org_x,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_org_y,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_ext_w,
    input  logic [NUM_LAYERS*COORD_W-1:0] lay_ext_h,
    input  logic [NUM_LAYERS-1:0]         lay_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0]  lay_prio,
    input  logic [NUM_LAYERS*CH_W-1:0]    lay_alpha,
    input  logic [NUM_LAYERS-1:0]         lay_alpha_en,
    input  logic                          pix_valid,
    input  logic [COORD_W-1:0]            pix_x,
    input  logic [COORD_W-1:0]            pix_y,
    input  logic [NUM_LAYERS*PIX_W-1:0]   lay_pix,
    output logic                          out_valid,
    output logic [PIX_W-1:0]              out_pix
);
    localparam int NUM_PIPES = 2;

    logic [NUM_LAYERS-1:0]      hits;
    logic [NUM_LAYERS*CH_W-1:0] eff_alpha;
    pick_t                      picks [NUM_PIPES];
    rgb_t                       mix_low;
    rgb_t                       mix_high;
    logic                       in_frame;
    logic                       keep_low;
    pipe_state_t                st_d;
    pipe_state_t                st_q;

    // Stage 1: coverage test and effective alpha for every layer.
    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
        comp_layer_hit #(.COORD_W(COORD_W)) u_hit (
            .en    (lay_en[i]),
            .org_x (lay_org_x[i*COORD_W +: COORD_W]),
            .org_y (lay_org_y[i*COORD_W +: COORD_W]),
            .ext_w (lay_ext_w[i*COORD_W +: COORD_W]),
            .ext_h (lay_ext_h[i*COORD_W +: COORD_W]),
            .pos_x (pix_x),
            .pos_y (pix_y),
            .hit   (hits[i])
        );
        assign eff_alpha[i*CH_W +: CH_W] = lay_alpha_en[i] ? lay_alpha[i*CH_W +: CH_W]
                                                           : ALPHA_OPAQUE;
    end

    // Stage 1: one priority pick per pipe; only pipe 0 can carry the defect.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        comp_pipe_pick #(
            .NUM_LAYERS (NUM_LAYERS),
            .PRIO_W     (PRIO_W),
            .PIPE_ID    (p[0]),
            .FLAW_ABLE  (p == 0)
        ) u_pick (
            .hits       (hits),
            .pipe_of    (lay_pipe),
            .prio_flat  (lay_prio),
            .alpha_flat (eff_alpha),
            .pix_flat   (lay_pix),
            .flaw_mode  (flaw_mode),
            .pick       (picks[p])
        );
    end

    // Stage 1 mix: the pipe 0 winner over the background.
    comp_blend u_mix_low (
        .alpha (picks[0].alpha),
        .top   (picks[0].pix),
        .bot   (bg_color),
        .mix   (mix_low)
    );

    // Stage 2 mix: the registered pipe 1 winner over the registered bottom.
    comp_blend u_mix_high (
        .alpha (st_q.s1_top_a),
        .top   (st_q.s1_top_pix),
        .bot   (st_q.s1_bot),
        .mix   (mix_high)
    );

    always_comb begin
        st_d     = st_q;
        in_frame = (pix_x < frame_w) && (pix_y < frame_h);
        keep_low = picks[0].found && !picks[0].blank;

        st_d.s1_v       = pix_valid && in_frame;
        st_d.s1_bot     = keep_low ? mix_low : bg_color;
        st_d.s1_top_hit = picks[1].found && !picks[1].blank;
        st_d.s1_top_a   = picks[1].alpha;
        st_d.s1_top_pix = picks[1].pix;

        st_d.out_v   = st_q.s1_v;
        st_d.out_pix = st_q.s1_top_hit ? mix_high : st_q.s1_bot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_v;
    assign out_pix   = st_q.out_pix;
endmodule

// File: rtl/comp_checker.sv
module comp_checker
    import comp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int COORD_W    = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pix_valid,
    input logic [COORD_W-1:0]    pix_x,
    input logic [COORD_W-1:0]    pix_y,
    input logic [COORD_W-1:0]    frame_w,
    input logic [COORD_W-1:0]    frame_h,
    input logic [NUM_LAYERS-1:0] lay_en,
    input logic [PIX_W-1:0]      bg_color,
    input logic                  out_valid,
    input logic [PIX_W-1:0]      out_pix
);
    logic [1:0] warm;
    logic       ready;

    // Counts edges since reset so that no check looks back past it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end
    assign ready = (warm >= 2'd2);

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid)
        else $error("out_valid high right after reset");

    p_two_cycle_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_valid == ($past(pix_valid, 2) &&
                                 ($past(pix_x, 2) < $past(frame_w, 2)) &&
                                 ($past(pix_y, 2) < $past(frame_h, 2)))))
        else $error("out_valid does not follow the input two cycles back");

    p_frame_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && out_valid) |-> (($past(pix_x, 2) < $past(frame_w, 2)) &&
                                  ($past(pix_y, 2) < $past(frame_h, 2))))
        else $error("valid output for a position outside the frame");

    p_no_layer_bg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && out_valid && ($past(lay_en, 2) == '0)) |->
            (out_pix == $past(bg_color, 2)))
        else $error("no layer enabled yet output differs from background");
endmodule

bind dual_pipe_compositor comp_checker #(
    .NUM_LAYERS (NUM_LAYERS),
    .COORD_W    (COORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .frame_w   (frame_w),
    .frame_h   (frame_h),
    .lay_en    (lay_en),
    .bg_color  (bg_color),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/tb_dual_pipe_compositor.sv
module tb_dual_pipe_compositor;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int CW = 12;
    localparam int PW = 2;
    localparam int WATCHDOG_CYCLES = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CW-1:0]    frame_w = '0;
    logic [CW-1:0]    frame_h = '0;
    logic [23:0]      bg_color = '0;
    logic             flaw_mode = 1'b0;
    logic [NL-1:0]    lay_en = '0;
    logic [NL*CW-1:0] lay_org_x = '0;
    logic [NL*CW-1:0] lay_org_y = '0;
    logic [NL*CW-1:0] lay_ext_w = '0;
    logic [NL*CW-1:0] lay_ext_h = '0;
    logic [NL-1:0]    lay_pipe = '0;
    logic [NL*PW-1:0] lay_prio = '0;
    logic [NL*8-1:0]  lay_alpha = '0;
    logic [NL-1:0]    lay_alpha_en = '0;
    logic             pix_valid = 1'b0;
    logic [CW-1:0]    pix_x = '0;
    logic [CW-1:0]    pix_y = '0;
    logic [NL*24-1:0] lay_pix = '0;
    logic             out_valid;
    logic [23:0]      out_pix;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Bench copy of the configuration, used by the model.
    int m_en [NL], m_x [NL], m_y [NL], m_w [NL], m_h [NL];
    int m_pipe [NL], m_prio [NL], m_alpha [NL], m_aen [NL];
    int m_fw, m_fh, m_bg;
    bit m_flaw;

    // Two-entry queue of expected results.
    bit ev1 = 0, ev2 = 0;
    int ep1 = 0, ep2 = 0;
    int ex1 = 0, ey1 = 0, ex2 = 0, ey2 = 0;
    string tg1 = "idle", tg2 = "idle";

    dual_pipe_compositor #(.NUM_LAYERS(NL), .COORD_W(CW), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
        .bg_color(bg_color), .flaw_mode(flaw_mode), .lay_en(lay_en),
        .lay_org_x(lay_org_x), .lay_org_y(lay_org_y), .lay_ext_w(lay_ext_w),
        .lay_ext_h(lay_ext_h), .lay_pipe(lay_pipe), .lay_prio(lay_prio),
        .lay_alpha(lay_alpha), .lay_alpha_en(lay_alpha_en), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .lay_pix(lay_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lpix(input int i, input int x, input int y);
        return (((x*37 + i*61) & 255) << 16) | (((y*29 + i*83) & 255) << 8) |
               (((x + y)*13 + i*47) & 255);
    endfunction

    function automatic int mixc(input int a, input int t, input int b);
        return (a*t + (255 - a)*b + 127) / 255;
    endfunction

    function automatic int mixrgb(input int a, input int t, input int b);
        int r = 0;
        for (int k = 0; k < 3; k++)
            r |= mixc(a, (t >> (8*k)) & 255, (b >> (8*k)) & 255) << (8*k);
        return r;
    endfunction

    function automatic int ealpha(input int i);
        return m_aen[i] != 0 ? m_alpha[i] : 255;
    endfunction

    task automatic model(input int x, input int y, output bit v, output int p);
        int best [2];
        int bot;
        v = (x < m_fw) && (y < m_fh);
        for (int q = 0; q < 2; q++) begin
            best[q] = -1;
            for (int i = 0; i < NL; i++) begin
                if (m_en[i] != 0 && m_pipe[i] == q && x >= m_x[i] && x < m_x[i] + m_w[i] &&
                    y >= m_y[i] && y < m_y[i] + m_h[i] &&
                    (best[q] < 0 || m_prio[i] > m_prio[best[q]]))
                    best[q] = i;
            end
        end
        bot = m_bg;
        if (best[0] >= 0 && !(m_flaw && m_prio[best[0]] == 0 && ealpha(best[0]) != 255))
            bot = mixrgb(ealpha(best[0]), lpix(best[0], x, y), m_bg);
        p = bot;
        if (best[1] >= 0)
            p = mixrgb(ealpha(best[1]), lpix(best[1], x, y), bot);
    endtask

    task automatic set_layer(input int i, input int en, input int x, input int y,
                             input int w, input int h, input int pipe, input int prio,
                             input int alpha, input int aen);
        m_en[i] = en; m_x[i] = x; m_y[i] = y; m_w[i] = w; m_h[i] = h;
        m_pipe[i] = pipe; m_prio[i] = prio; m_alpha[i] = alpha; m_aen[i] = aen;
        lay_en[i] = (en != 0);
        lay_org_x[i*CW +: CW] = CW'(x);
        lay_org_y[i*CW +: CW] = CW'(y);
        lay_ext_w[i*CW +: CW] = CW'(w);
        lay_ext_h[i*CW +: CW] = CW'(h);
        lay_pipe[i] = pipe[0];
        lay_prio[i*PW +: PW] = PW'(prio);
        lay_alpha[i*8 +: 8] = 8'(alpha);
        lay_alpha_en[i] = (aen != 0);
    endtask

    task automatic set_frame(input int w, input int h, input int bg, input bit flaw);
        m_fw = w; m_fh = h; m_bg = bg; m_flaw = flaw;
        frame_w = CW'(w); frame_h = CW'(h); bg_color = 24'(bg); flaw_mode = flaw;
    endtask

    // Checks the result of the position driven two steps ago, then drives a new one.
    task automatic step(input bit v, input int x, input int y, input string tag);
        bit nv;
        int np;
        @(negedge clk);
        checks++;
        if (out_valid !== ev2 || (ev2 && out_pix !== 24'(ep2))) begin
            fails++;
            $display("FAIL %s at x=%0d y=%0d: actual valid=%0b pix=%06h expected valid=%0b pix=%06h",
                     tg2, ex2, ey2, out_valid, out_pix, ev2, 24'(ep2));
        end
        ev2 = ev1; ep2 = ep1; ex2 = ex1; ey2 = ey1; tg2 = tg1;
        if (v) model(x, y, nv, np);
        else begin nv = 0; np = 0; end
        ev1 = nv; ep1 = np; ex1 = x; ey1 = y; tg1 = tag;
        pix_valid = v;
        pix_x = CW'(x);
        pix_y = CW'(y);
        for (int i = 0; i < NL; i++) lay_pix[i*24 +: 24] = 24'(lpix(i, x, y));
    endtask

    // Sweeps every position plus two rows and columns past the frame, then flushes.
    task automatic sweep(input string tag);
        for (int y = 0; y < m_fh + 2; y++)
            for (int x = 0; x < m_fw + 2; x++)
                step(1'b1, x, y, tag);
        step(1'b0, 0, 0, tag);
        step(1'b0, 0, 0, tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual=still running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) set_layer(i, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_frame(8, 6, 0, 1'b0);

        // R1: idle during reset and right after release.
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: actual=%0b expected=0", out_valid);
        end
        pix_valid = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release: actual=%0b expected=0", out_valid);
        end
        pix_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ev1 = 0; ev2 = 0;

        // R7 R4 R3: background only; layer 2 covers all but is disabled.
        set_frame(8, 6, 24'h102030, 1'b0);
        set_layer(2, 0, 0, 0, 8, 6, 1, 3, 8'h80, 1);
        sweep("R7 R4 R3 background");

        // R5 R6 R4: one pipe, opaque, overlapping; layers 1 and 3 share priority 3.
        set_frame(8, 6, 24'h000000, 1'b0);
        set_layer(0, 1, 0, 0, 6, 4, 0, 2, 0, 0);
        set_layer(1, 1, 2, 1, 4, 4, 0, 3, 0, 0);
        set_layer(2, 1, 1, 0, 8, 6, 0, 1, 0, 0);
        set_layer(3, 1, 3, 2, 5, 3, 0, 3, 0, 0);
        sweep("R5 R6 R4 priority");

        // R8 R9: both pipes with alpha; layer 0 has alpha set but its enable clear.
        set_frame(8, 6, 24'h204060, 1'b0);
        set_layer(0, 1, 0, 0, 8, 6, 0, 0, 8'h10, 0);
        set_layer(3, 1, 4, 0, 4, 6, 0, 1, 8'hC0, 1);
        set_layer(1, 1, 0, 2, 5, 3, 1, 1, 8'h80, 1);
        set_layer(2, 1, 3, 0, 3, 4, 1, 2, 8'h40, 1);
        sweep("R8 R9 blend");

        // R10: compatibility mode with a translucent priority-0 pipe 0 layer.
        set_frame(8, 6, 24'h405060, 1'b1);
        set_layer(0, 1, 0, 0, 4, 6, 0, 0, 8'h80, 1);
        set_layer(3, 1, 2, 0, 4, 6, 0, 1, 0, 0);
        set_layer(1, 1, 3, 1, 4, 3, 1, 0, 8'h60, 1);
        set_layer(2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        sweep("R10 flaw translucent");

        // R10: an opaque priority-0 layer is untouched by the mode.
        set_layer(0, 1, 0, 0, 4, 6, 0, 0, 8'hFF, 1);
        sweep("R10 flaw opaque");

        // R10 R8: same translucent layer with the mode off is blended normally.
        set_frame(8, 6, 24'h405060, 1'b0);
        set_layer(0, 1, 0, 0, 4, 6, 0, 0, 8'h80, 1);
        sweep("R10 R8 flaw off");

        // R11 R4 R3: empty rectangles, corner pixels, a different frame size.
        set_frame(7, 5, 24'h0A0B0C, 1'b0);
        set_layer(0, 1, 2, 2, 0, 3, 1, 3, 0, 0);
        set_layer(1, 1, 1, 1, 4, 0, 1, 3, 0, 0);
        set_layer(2, 1, 6, 4, 1, 1, 0, 0, 0, 0);
        set_layer(3, 1, 0, 0, 1, 1, 1, 3, 8'h33, 1);
        sweep("R11 R4 R3 edges");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule